// File: doc/BRIEF.md
# System Clock Source Switch Monitor

This block chooses which of four clock sources drives the system clock and divides the chosen source down. The sources are an external crystal, an internal 22.1184 MHz oscillator, a PLL and an internal 10 kHz oscillator. The oscillators and the PLL sit outside the block. Each one is represented by an on input, a ready input and a tick input. The tick input is a one-cycle enable pulse in the single fast clock domain that stands for one edge of that source. The block emits a divided clock-enable pulse, `clk_en_o`, for the logic that runs from the system clock.

Software asks for a new source by writing a 3-bit select code. The switch commits only if both the source now in use and the requested source report stable. Otherwise the request is refused, the old source stays in use and a sticky fail flag is raised. Software clears the flag by writing 1 to it. The select readback always shows the source actually in use. After any reset the select comes from a configuration strap, which is either 000 or 111. A divide-number write is held back until the current divided period ends, so the output never carries a short period.

Top module: `sysclk_switch_mon`

## Requirements
- R1: While reset is active and after it is released, `sw_fail_o`, `div_o` and `clk_en_o` are 0. `sel_o` is 001 when `cfg_sel_i` is 111 and 000 for any other strap value.
- R2: `stable_o[i]` equals `src_on_i[i] & src_rdy_i[i]` delayed by one clock. Bit 0 is the crystal, bit 1 the 22.1184 MHz oscillator, bit 2 the PLL and bit 3 the 10 kHz oscillator.
- R3: A select write of 000, 001, 010 or 011 (crystal, 22.1184 MHz, PLL, 10 kHz) commits when the `stable_o` bits of both the current source and the requested source are 1. `sel_o` shows the new code one clock later.
- R4: A select write to a source whose `stable_o` bit is 0 is refused. `sel_o` keeps its value and `sw_fail_o` is 1 one clock later.
- R5: A select write is also refused, and sets `sw_fail_o`, when the `stable_o` bit of the source currently in use is 0.
- R6: Select code 111 selects the 22.1184 MHz oscillator and reads back as 001. Codes 100, 101 and 110 are always refused and set `sw_fail_o`.
- R7: `fail_clr_i` clears `sw_fail_o` on the next clock. When a refused write happens in the same cycle, the flag stays 1.
- R8: `clk_en_o` pulses once for every `div_o`+1 ticks of the selected source, one clock after the tick that ends the period. Ticks of sources not in use have no effect on it.
- R9: A divide-number write changes `div_o` only on the clock edge that raises `clk_en_o`. That edge also starts the next period with the new ratio. A write made in the cycle of that boundary is applied at that boundary.
- R10: A committed switch restarts the divided period. No `clk_en_o` is produced on the switch edge, and the first pulse comes after `div_o`+1 ticks of the new source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast control clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_sel_i | input | 3 | Reset-time select strap (000 or 111) |
| src_on_i | input | 4 | Source enabled, one bit per source |
| src_rdy_i | input | 4 | Source reports settled output |
| src_tick_i | input | 4 | One-cycle pulse per source edge |
| sel_wr_i | input | 1 | Select write strobe |
| sel_wdata_i | input | 3 | Requested select code |
| div_wr_i | input | 1 | Divide-number write strobe |
| div_wdata_i | input | 4 | Requested divide number |
| fail_clr_i | input | 1 | Write-1-to-clear for the fail flag |
| sel_o | output | 3 | Code of the source in use |
| div_o | output | 4 | Divide number in effect |
| stable_o | output | 4 | Per-source stable flags |
| sw_fail_o | output | 1 | Sticky switch-fail flag |
| clk_en_o | output | 1 | Divided system clock enable |

## Verification
The hardest situations to reach from the ports are the collisions. One is a divide-number write that lands exactly on a period boundary. Another is a refused switch and a clear in the same cycle. A third is a switch that commits while a source tick arrives. The directed part forces the set-versus-clear and current-source-unstable cases. Long random runs then mix ticks, select writes with reserved codes, divide writes and flickering ready bits at rates that make the three collisions happen many times. A bench reference model compares every output on every cycle.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int NSRC  = 4;
  localparam int SEL_W = 3;
  localparam int SRC_W = $clog2(NSRC);

  typedef enum logic [SRC_W-1:0] {
    SRC_XTAL = 2'd0,
    SRC_HIRC = 2'd1,
    SRC_PLL  = 2'd2,
    SRC_LIRC = 2'd3
  } src_e;

  typedef struct packed {
    logic ok;
    src_e src;
  } sel_dec_t;

  function automatic sel_dec_t decode_sel(input logic [SEL_W-1:0] code);
    sel_dec_t d;
    d.ok  = 1'b1;
    d.src = SRC_XTAL;
    case (code)
      3'b000:  d.src = SRC_XTAL;
      3'b001:  d.src = SRC_HIRC;
      3'b010:  d.src = SRC_PLL;
      3'b011:  d.src = SRC_LIRC;
      3'b111:  d.src = SRC_HIRC;
      default: d.ok  = 1'b0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/sysclk_stable_flags.sv
module sysclk_stable_flags #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] on_i,
  input  logic [N-1:0] rdy_i,
  output logic [N-1:0] stable_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stable_o[g] <= 1'b0;
      else         stable_o[g] <= on_i[g] & rdy_i[g];
    end
  end
endmodule

// File: rtl/sysclk_sel_ctrl.sv
module sysclk_sel_ctrl
  import sysclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] cfg_sel_i,
  input  logic [NSRC-1:0]  stable_i,
  input  logic             wr_i,
  input  logic [SEL_W-1:0] wdata_i,
  input  logic             clr_i,
  output src_e             cur_o,
  output logic             commit_o,
  output logic             fail_o
);
  sel_dec_t req;
  logic     refuse;
  src_e     rst_src;

  assign rst_src  = (cfg_sel_i == 3'b111) ? SRC_HIRC : SRC_XTAL;
  assign req      = decode_sel(wdata_i);
  // both old and new source must be running
  assign commit_o = wr_i & req.ok & stable_i[req.src] & stable_i[cur_o];
  assign refuse   = wr_i & ~commit_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cur_o <= rst_src;
    else if (commit_o) cur_o <= req.src;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     fail_o <= 1'b0;
    else if (refuse) fail_o <= 1'b1;
    else if (clr_i)  fail_o <= 1'b0;
  end
endmodule

// File: rtl/sysclk_divider.sv
module sysclk_divider #(
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic             wr_i,
  input  logic [DIV_W-1:0] wdata_i,
  output logic [DIV_W-1:0] div_o,
  output logic             clk_en_o
);
  logic [DIV_W-1:0] cnt_q, pend_q, pend_d;
  logic             wrap;

  assign pend_d = wr_i ? wdata_i : pend_q;
  assign wrap   = tick_i & (cnt_q == div_o) & ~restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      pend_q   <= '0;
      div_o    <= '0;
      clk_en_o <= 1'b0;
    end else begin
      pend_q   <= pend_d;
      clk_en_o <= wrap;
      if (restart_i) begin
        cnt_q <= '0;
      end else if (wrap) begin
        cnt_q <= '0;
        div_o <= pend_d;  // ratio changes only at a period boundary
      end else if (tick_i) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sysclk_switch_mon.sv
module sysclk_switch_mon
  import sysclk_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       cfg_sel_i,
  input  logic [3:0]       src_on_i,
  input  logic [3:0]       src_rdy_i,
  input  logic [3:0]       src_tick_i,
  input  logic             sel_wr_i,
  input  logic [2:0]       sel_wdata_i,
  input  logic             div_wr_i,
  input  logic [DIV_W-1:0] div_wdata_i,
  input  logic             fail_clr_i,
  output logic [2:0]       sel_o,
  output logic [DIV_W-1:0] div_o,
  output logic [3:0]       stable_o,
  output logic             sw_fail_o,
  output logic             clk_en_o
);
  src_e cur;
  logic commit;
  logic tick;

  sysclk_stable_flags #(.N(NSRC)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .on_i     (src_on_i),
    .rdy_i    (src_rdy_i),
    .stable_o (stable_o)
  );

  sysclk_sel_ctrl u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_sel_i (cfg_sel_i),
    .stable_i  (stable_o),
    .wr_i      (sel_wr_i),
    .wdata_i   (sel_wdata_i),
    .clr_i     (fail_clr_i),
    .cur_o     (cur),
    .commit_o  (commit),
    .fail_o    (sw_fail_o)
  );

  assign tick  = src_tick_i[cur];
  assign sel_o = {1'b0, cur};

  sysclk_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .restart_i (commit),
    .wr_i      (div_wr_i),
    .wdata_i   (div_wdata_i),
    .div_o     (div_o),
    .clk_en_o  (clk_en_o)
  );
endmodule

// File: rtl/sysclk_switch_mon_chk.sv
module sysclk_switch_mon_chk #(
  parameter int DIV_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [3:0]       src_tick_i,
  input logic             sel_wr_i,
  input logic             fail_clr_i,
  input logic [2:0]       sel_o,
  input logic [DIV_W-1:0] div_o,
  input logic             sw_fail_o,
  input logic             clk_en_o
);
  // R4: a refusal never moves the selection
  p_sel_hold_on_fail_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_fail_o) |-> $stable(sel_o));

  // R6: readback only ever names one of the four sources
  p_sel_legal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o[2] == 1'b0);

  // R7: a clear with no write in the same cycle empties the flag
  p_fail_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_clr_i && !sel_wr_i) |=> !sw_fail_o);

  // R8: each output pulse follows a tick of the source in use
  p_pulse_from_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o |-> $past(src_tick_i[sel_o[1:0]]));

  // R9: ratio changes only together with a boundary pulse
  p_div_at_boundary_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(div_o) |-> clk_en_o);
endmodule

bind sysclk_switch_mon sysclk_switch_mon_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_tick_i (src_tick_i),
  .sel_wr_i   (sel_wr_i),
  .fail_clr_i (fail_clr_i),
  .sel_o      (sel_o),
  .div_o      (div_o),
  .sw_fail_o  (sw_fail_o),
  .clk_en_o   (clk_en_o)
);

// File: tb/sysclk_switch_mon_tb.sv
module sysclk_switch_mon_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [2:0]       cfg_sel = 3'b000;
  logic [3:0]       src_on = '0, src_rdy = '0, src_tick = '0;
  logic             sel_wr = 1'b0;
  logic [2:0]       sel_wd = '0;
  logic             div_wr = 1'b0;
  logic [DIV_W-1:0] div_wd = '0;
  logic             fail_clr = 1'b0;
  logic [2:0]       sel_o;
  logic [DIV_W-1:0] div_o;
  logic [3:0]       stable_o;
  logic             sw_fail_o, clk_en_o;

  int checks = 0, failures = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysclk_switch_mon #(.DIV_W(DIV_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_sel_i(cfg_sel),
    .src_on_i(src_on), .src_rdy_i(src_rdy), .src_tick_i(src_tick),
    .sel_wr_i(sel_wr), .sel_wdata_i(sel_wd),
    .div_wr_i(div_wr), .div_wdata_i(div_wd), .fail_clr_i(fail_clr),
    .sel_o(sel_o), .div_o(div_o), .stable_o(stable_o),
    .sw_fail_o(sw_fail_o), .clk_en_o(clk_en_o)
  );

  // reference model state, written from the requirements
  int               m_sel;
  bit               m_fail, m_pulse;
  logic [3:0]       m_stab;
  int               m_cnt;
  logic [DIV_W-1:0] m_act, m_pend;

  function automatic int code_to_src(input logic [2:0] c);
    if (c == 3'b111) return 1;
    if (c[2]) return -1;
    return int'(c[1:0]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel = (cfg_sel == 3'b111) ? 1 : 0;
      m_fail = 0; m_pulse = 0; m_stab = '0; m_cnt = 0; m_act = '0; m_pend = '0;
    end else begin
      logic [DIV_W-1:0] np;
      int  req;
      bit  cmt;
      np  = div_wr ? div_wd : m_pend;
      req = code_to_src(sel_wd);
      cmt = sel_wr && req >= 0 && m_stab[req] && m_stab[m_sel];
      m_fail = (sel_wr && !cmt) ? 1'b1 : (fail_clr ? 1'b0 : m_fail);
      m_pulse = 0;
      if (cmt) begin
        m_cnt = 0;
      end else if (src_tick[m_sel]) begin
        if (m_cnt == int'(m_act)) begin
          m_pulse = 1; m_cnt = 0; m_act = np;
        end else m_cnt++;
      end
      if (cmt) m_sel = req;
      m_pend = np;
      m_stab = src_on & src_rdy;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on && rst_n) begin
    chk("R3 sel_o", int'(sel_o), m_sel);
    chk("R4/R7 sw_fail_o", int'(sw_fail_o), int'(m_fail));
    chk("R2 stable_o", int'(stable_o), int'(m_stab));
    chk("R9 div_o", int'(div_o), int'(m_act));
    chk("R8/R10 clk_en_o", int'(clk_en_o), int'(m_pulse));
  end

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [2:0] cfg);
    cfg_sel = cfg;
    rst_n = 1'b0;
    step(3);
    // R1: values held during reset
    chk("R1 sel in reset", int'(sel_o), (cfg == 3'b111) ? 1 : 0);
    chk("R1 fail in reset", int'(sw_fail_o), 0);
    rst_n = 1'b1;
    step(1);
    chk("R1 div after reset", int'(div_o), 0);
    chk("R1 clk_en after reset", int'(clk_en_o), 0);
  endtask

  task automatic sel_write(input logic [2:0] c, input bit clr = 1'b0);
    sel_wr = 1'b1; sel_wd = c; fail_clr = clr;
    step(1);
    sel_wr = 1'b0; fail_clr = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    step(2);
    do_reset(3'b000);
    cmp_on = 1'b1;
    src_on = 4'hF; src_rdy = 4'hF;
    step(2);
    chk("R2 all stable", int'(stable_o), 15);
    sel_write(3'b010);
    chk("R3 switch to PLL", int'(sel_o), 2);
    src_rdy[0] = 1'b0; step(2);
    sel_write(3'b000);
    chk("R4 refused sel", int'(sel_o), 2);
    chk("R4 fail set", int'(sw_fail_o), 1);
    src_rdy[0] = 1'b1; step(2);
    sel_write(3'b101, 1'b1);
    chk("R6 reserved refused", int'(sel_o), 2);
    chk("R7 set beats clear", int'(sw_fail_o), 1);
    fail_clr = 1'b1; step(1); fail_clr = 1'b0;
    chk("R7 cleared", int'(sw_fail_o), 0);
    sel_write(3'b111);
    chk("R6 code 111 reads 001", int'(sel_o), 1);
    src_rdy[1] = 1'b0; step(2);
    sel_write(3'b011);
    chk("R5 current unstable refused", int'(sel_o), 1);
    chk("R5 fail set", int'(sw_fail_o), 1);
    src_rdy[1] = 1'b1; step(2);
    // R9/R8: ratio 3 on the running source, ticks on every cycle
    src_tick = 4'b0010;
    div_wr = 1'b1; div_wd = 4'd2; step(1); div_wr = 1'b0;
    step(8);
    chk("R9 new ratio active", int'(div_o), 2);
    src_tick = 4'b1101;  // R8: other sources ticking only
    step(6);
    chk("R8 no pulse from idle sources", int'(clk_en_o), 0);
    sel_write(3'b000);   // R10: restart on switch, model checks each cycle
    step(6);
    do_reset(3'b111);
    src_on = 4'hF; src_rdy = 4'hF;
    step(2);
    // random phase
    for (int i = 0; i < 20000; i++) begin
      src_tick = 4'($urandom);
      src_rdy  = 4'hF & ~(($urandom % 6 == 0) ? 4'(1 << ($urandom % 4)) : 4'h0);
      src_on   = 4'hF & ~(($urandom % 40 == 0) ? 4'(1 << ($urandom % 4)) : 4'h0);
      sel_wr   = ($urandom % 8 == 0);
      sel_wd   = 3'($urandom);
      div_wr   = ($urandom % 16 == 0);
      div_wd   = 4'($urandom % 4);
      fail_clr = ($urandom % 6 == 0);
      step(1);
    end
    sel_wr = 1'b0; div_wr = 1'b0; fail_clr = 1'b0;
    step(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule